// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by reading the page tables in memory. A miss request carries a 36-bit virtual page number (bits 47:12 of a 48-bit virtual address). The walker then performs up to four dependent 8-byte reads, one for each table level. The first read uses a root table pointer, and every later read uses the table pointer found in the entry just returned. The walk ends with a 28-bit physical page number (a 40-bit physical address with 4 KiB pages) and the permission bits, or with a page fault that names the level where the walk stopped.

Only one walk runs at a time, and there is never more than one memory read outstanding. The unit that detected the miss raises a request while the walker is ready. It then waits for the single-cycle response pulse. The memory side takes a one-cycle read strobe together with its address, and later returns one data beat with a valid strobe.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: Read k (k = 0..3) goes to address {table_ppn, field_k, 3'b000}. Field 0 is vpn[35:27], field 1 is vpn[26:18], field 2 is vpn[17:9] and field 3 is vpn[8:0]. For read 0, table_ppn is `root_ppn_i`. For every later read it is the pointer from the previous entry. A successful walk makes exactly four reads and reports level 3.
- R3: The entry layout is as follows: bit 0 is present, bit 1 is writable, bit 2 is user, and bits 39:12 hold the next table or page PPN. All other bits are ignored. On success, `rsp_ppn_o` equals the PPN field of the fourth entry.
- R4: If an entry read at level k has its present bit clear, the walk issues no further reads and responds with `rsp_fault_o`=1 and `rsp_level_o`=k.
- R5: On success, `rsp_writable_o` and `rsp_user_o` are the AND of that bit across all four entries. On a fault, `rsp_ppn_o`, `rsp_writable_o` and `rsp_user_o` are all 0.
- R6: Each read strobe lasts one cycle, and no new read is issued until the response to the previous read has been taken.
- R7: `req_ready_o` is high only while idle. Request-side inputs that change while a walk is running have no effect on its result.
- R8: A memory response that arrives while no read is outstanding is ignored. This includes a response while idle and a response in the same cycle as the read strobe.
- R9: `rsp_valid_o` is a one-cycle pulse, and `req_ready_o` is high in the cycle after it.
- R10: `root_ppn_i` is captured when the request is accepted. Later changes to it do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_ppn_i | input | 28 | PPN of the top-level table |
| req_valid_i | input | 1 | Miss request strobe |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vpn_i | input | 36 | Virtual page number to translate |
| mem_req_valid_o | output | 1 | Entry read strobe |
| mem_req_addr_o | output | 40 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 64 | Entry data |
| rsp_valid_o | output | 1 | Walk result pulse |
| rsp_fault_o | output | 1 | Page fault |
| rsp_ppn_o | output | 28 | Translated PPN |
| rsp_writable_o | output | 1 | Combined write permission |
| rsp_user_o | output | 1 | Combined user permission |
| rsp_level_o | output | 2 | Level of the last entry read |

## Verification
The assertions check the following on every cycle: the read strobe stays one cycle long, there is only one read in flight, the result pulse lasts one cycle, the walker is not ready while busy and stays idle when a stray response arrives, a fault result carries a clean payload, and a success reports the last level. Only the bench scenarios can show that each level uses the correct 9-bit slice and table pointer, that the permission AND and the fault level are correct for every position of a cleared bit, and that request, root and memory inputs changed mid-walk are ignored. The bench sweeps every combination of fault level, cleared-writable level and cleared-user level under varied memory latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTE_W       = 64;
  localparam int unsigned PTE_P_BIT   = 0;
  localparam int unsigned PTE_WR_BIT  = 1;
  localparam int unsigned PTE_US_BIT  = 2;
  localparam int unsigned PTE_PPN_LSB = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } ptw_state_e;

  typedef struct packed {
    logic user;
    logic writable;
    logic present;
  } pte_flags_t;
endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] slc [LEVELS];

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slc[g] = vpn_i[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign idx_o = slc[level_i];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned PPN_W = PA_W - PAGE_W,
  localparam int unsigned PAD_W = PAGE_W - IDX_W
) (
  input  logic [PPN_W-1:0] base_ppn_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  assign addr_o = {base_ppn_i, idx_i, {PAD_W{1'b0}}};
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic take_i,
  input  logic wr_i,
  input  logic us_i,
  output logic wr_acc_o,
  output logic us_acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_acc_o <= 1'b0;
      us_acc_o <= 1'b0;
    end else if (clear_i) begin
      wr_acc_o <= 1'b1;
      us_acc_o <= 1'b1;
    end else if (take_i) begin
      wr_acc_o <= wr_acc_o & wr_i;
      us_acc_o <= us_acc_o & us_i;
    end
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             mem_rsp_valid_i,
  input  logic             present_i,
  output logic             req_ready_o,
  output logic             accept_o,
  output logic             mem_req_valid_o,
  output logic             take_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             rsp_valid_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  ptw_state_e       state_q, state_d;
  logic [LVL_W-1:0] level_q;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  // responses count only while a read is outstanding
  assign take_o          = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign finish_o        = take_o && (!present_i || level_q == LAST_LVL);
  assign step_o          = take_o && present_i && level_q != LAST_LVL;
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign level_o         = level_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (finish_o) state_d = ST_DONE;
                else if (step_o) state_d = ST_ISSUE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      level_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o)    level_q <= '0;
      else if (step_o) level_q <= level_q + 1'b1;
    end
  end

  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o); // R7
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> req_ready_o && !mem_req_valid_o); // R8
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned PA_W   = 40,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned PPN_W = PA_W - PAGE_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  output logic             mem_req_valid_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_writable_o,
  output logic             rsp_user_o,
  output logic [LVL_W-1:0] rsp_level_o
);
  logic             accept, take, step, finish;
  logic [LVL_W-1:0] level;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] base_q;
  logic [IDX_W-1:0] idx;
  logic             wr_acc, us_acc;
  pte_flags_t       flags;
  logic [PPN_W-1:0] pte_ppn;

  assign flags.present  = mem_rsp_data_i[PTE_P_BIT];
  assign flags.writable = mem_rsp_data_i[PTE_WR_BIT];
  assign flags.user     = mem_rsp_data_i[PTE_US_BIT];
  assign pte_ppn        = mem_rsp_data_i[PTE_PPN_LSB +: PPN_W];

  ptw_fsm #(.LEVELS(LEVELS)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .present_i       (flags.present),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .take_o          (take),
    .step_o          (step),
    .finish_o        (finish),
    .rsp_valid_o     (rsp_valid_o),
    .level_o         (level)
  );

  ptw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
    .vpn_i   (vpn_q),
    .level_i (level),
    .idx_o   (idx)
  );

  ptw_entry_addr #(.PA_W(PA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
    .base_ppn_i (base_q),
    .idx_i      (idx),
    .addr_o     (mem_req_addr_o)
  );

  ptw_perm_acc u_perm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .take_i   (take),
    .wr_i     (flags.writable),
    .us_i     (flags.user),
    .wr_acc_o (wr_acc),
    .us_acc_o (us_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      vpn_q  <= req_vpn_i;
      base_q <= root_ppn_i;
    end else if (step) begin
      base_q <= pte_ppn;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_fault_o    <= 1'b0;
      rsp_ppn_o      <= '0;
      rsp_writable_o <= 1'b0;
      rsp_user_o     <= 1'b0;
      rsp_level_o    <= '0;
    end else if (finish) begin
      rsp_fault_o    <= !flags.present;
      rsp_ppn_o      <= flags.present ? pte_ppn : '0;
      rsp_writable_o <= flags.present && wr_acc && flags.writable;
      rsp_user_o     <= flags.present && us_acc && flags.user;
      rsp_level_o    <= level;
    end
  end

  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_ppn_o == '0 && !rsp_writable_o && !rsp_user_o)); // R5
  AST_OK_LAST_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_level_o == LVL_W'(LEVELS - 1)); // R2
  AST_NO_READ_AT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o); // R4
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] root_ppn_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [35:0] req_vpn_i = '0;
  logic        mem_req_valid_o;
  logic [39:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o, rsp_fault_o, rsp_writable_o, rsp_user_o;
  logic [27:0] rsp_ppn_o;
  logic [1:0]  rsp_level_o;

  always #4 clk_i = ~clk_i;

  ptw_walker dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int lat = 1, fault_lvl = 4, wr_lvl = 4, us_lvl = 4, rd_cnt = 0, addr_bad = 0;
  bit spur = 0, pend = 0;
  int pcnt = 0;
  logic [63:0] pdata;
  logic [39:0] exp_addr [4];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] ppn_hash(logic [39:0] a);
    logic [63:0] t;
    t = {24'd0, a} * 64'd2654435761;
    return t[47:20] ^ a[30:3];
  endfunction

  function automatic logic [63:0] make_pte(logic [39:0] a, int k);
    logic [63:0] e;
    e = {24'hA5C3E1, 40'd0};
    e[39:12] = ppn_hash(a);
    e[11:3]  = a[11:3];
    e[0] = (k != fault_lvl);
    e[1] = (k != wr_lvl);
    e[2] = (k != us_lvl);
    return e;
  endfunction

  // memory model: responds lat+1 cycles after the strobe
  always @(negedge clk_i) begin
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = pdata;
        pend = 0;
      end else pcnt--;
    end
    if (mem_req_valid_o) begin
      if (rd_cnt > 3 || mem_req_addr_o != exp_addr[rd_cnt]) addr_bad++;
      pdata = make_pte(mem_req_addr_o, rd_cnt);
      rd_cnt++;
      pend = 1;
      pcnt = lat;
      if (spur) begin
        mem_rsp_valid_i = 1'b1;  // R8: arrives in the strobe cycle
        mem_rsp_data_i  = '0;
      end
    end
  end

  task automatic walk(logic [35:0] vpn, logic [27:0] root, bit busy);
    logic [27:0] base;
    bit exp_fault;
    int reads, w;
    base = root;
    for (int l = 0; l < 4; l++) begin
      exp_addr[l] = {base, vpn[(3-l)*9 +: 9], 3'b000};
      base = ppn_hash(exp_addr[l]);
    end
    exp_fault = (fault_lvl < 4);
    reads = exp_fault ? fault_lvl + 1 : 4;
    rd_cnt = 0;
    addr_bad = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vpn_i   = vpn;
    root_ppn_i  = root;
    @(negedge clk_i);
    chk(!req_ready_o, "R7 ready while busy", req_ready_o, 0);
    if (busy) begin
      req_vpn_i  = ~vpn;   // R7 / R10: changes after acceptance
      root_ppn_i = ~root;
    end else req_valid_i = 1'b0;
    w = 0;
    while (!rsp_valid_o && w < 200) begin
      @(negedge clk_i);
      w++;
    end
    req_valid_i = 1'b0;
    chk(rsp_valid_o, "R9 response seen", rsp_valid_o, 1);
    chk(rsp_fault_o == exp_fault, "R4 fault flag", rsp_fault_o, exp_fault);
    chk(rsp_level_o == (exp_fault ? fault_lvl : 3), "R4 level", rsp_level_o,
        exp_fault ? fault_lvl : 3);
    chk(rsp_ppn_o == (exp_fault ? 28'd0 : base), "R3 ppn", rsp_ppn_o,
        exp_fault ? 28'd0 : base);
    chk(rsp_writable_o == (!exp_fault && wr_lvl >= 4), "R5 writable",
        rsp_writable_o, !exp_fault && wr_lvl >= 4);
    chk(rsp_user_o == (!exp_fault && us_lvl >= 4), "R5 user",
        rsp_user_o, !exp_fault && us_lvl >= 4);
    chk(rd_cnt == reads, "R6 read count", rd_cnt, reads);
    chk(addr_bad == 0, "R2 entry addresses", addr_bad, 0);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R9 pulse end", {rsp_valid_o, req_ready_o}, 2'b01);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20;
    chk(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1 reset state",
        {req_ready_o, mem_req_valid_o, rsp_valid_o}, 3'b100);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1 after release",
        {req_ready_o, mem_req_valid_o, rsp_valid_o}, 3'b100);

    // R8: stray responses while idle
    for (int i = 0; i < 3; i++) begin
      force mem_rsp_valid_i = 1'b1;
      force mem_rsp_data_i  = 64'hFFFF_FFFF_FFFF_FFFF;
      @(negedge clk_i);
      chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R8 idle response ignored",
          {req_ready_o, rsp_valid_o, mem_req_valid_o}, 3'b100);
    end
    release mem_rsp_valid_i;
    release mem_rsp_data_i;

    // R2: each field alone at its extremes
    for (int l = 0; l < 4; l++) begin
      lat = l;
      walk(36'h1FF << ((3 - l) * 9), 28'h0ABCDEF, 0);
      walk(36'h001 << ((3 - l) * 9), 28'hFFFFFFF, 0);
    end
    walk(36'h0, 28'h0, 0);
    walk(36'hF_FFFF_FFFF, 28'h1234567, 0);

    // R3 R4 R5 R7 R8 R10: full sweep of bit-clear positions
    for (int f = 0; f <= 4; f++)
      for (int w2 = 0; w2 <= 4; w2++)
        for (int u = 0; u <= 4; u++) begin
          fault_lvl = f;
          wr_lvl    = w2;
          us_lvl    = u;
          lat       = (f + w2 + u) % 4;
          spur      = (u == 2);
          walk(36'h123456789 ^ 36'(f * 36'h4D2B1 + w2 * 36'h71F3 + u * 36'h3A),
               28'(28'h0F0F0F0 + f * 28'h111 + u), w2 == 3);
        end
    spur = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule